// File: doc/BRIEF.md
# Timer-Tail Supervision Watchdog

This block guards against runaway software. A short binary counter, fed by a slow tick taken from the end of a free-running timer chain, advances once per tick. When it wraps past its top value, the block raises a one-cycle reset request for the system reset logic. Software prevents this by writing, at regular intervals, a value with bit 0 low to one fixed clear address. The clear bit can only be written. The block drives no read data, so a read of that address returns whatever memory sits there.

The counter keeps running while the processor is in run, wait or halt. When the processor enters stop, the counter is forced to zero and ticks are ignored, so the watchdog cannot fire while the part is stopped. Two static straps stand in for factory options. One makes a stop request behave as halt, and the counter then keeps running. The other turns the watchdog off altogether. A detector input that flags a high voltage on the programming pin also holds the watchdog off. While it is held off the counter stays at zero, so timing begins again from zero once the detector drops.

Top module: `cop_guard`

## Requirements
- R1: In run mode (cpuMode 0) each cycle with tick high advances the counter by one. With the default 3 stages, the 8th tick after a clear or reset makes rstReq high in the cycle right after the clock edge that samples that tick.
- R2: rstReq is high for exactly one cycle. The counter is back at zero afterwards, so the next request needs a further 8 ticks.
- R3: A cycle with wrEn high, wrAddr equal to 16'h03F0 and wrData bit 0 low zeroes the counter. Bits 7 to 1 of wrData do not matter, so data 8'hFE clears too.
- R4: A write to 16'h03F0 with wrData bit 0 high leaves the counter unchanged. So does a write of 0 to any other address.
- R5: When a clearing write and a tick fall in the same cycle, the clear wins and that tick is not counted.
- R6: Ticks are counted in wait (cpuMode 1) and halt (cpuMode 2) exactly as in run. A count built up across modes carries over between them.
- R7: In stop (cpuMode 3) with strapStopAsHalt low, the counter is held at zero and ticks are ignored, so rstReq stays low.
- R8: With strapStopAsHalt high, stop behaves as halt: ticks keep counting and the count is kept.
- R9: With strapDisable high, rstReq never asserts and the counter is held at zero.
- R10: While hvDetect is high, rstReq stays low and the counter is held at zero. After hvDetect falls, a full 8 fresh ticks are needed for a request.
- R11: While rstN is low and right after it is released, rstReq is low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | One-cycle advance strobe from the timer chain |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | ADDR_W (16) | CPU write address |
| wrData | input | DATA_W (8) | CPU write data; only bit 0 is used |
| cpuMode | input | 2 | 0 run, 1 wait, 2 halt, 3 stop |
| strapStopAsHalt | input | 1 | Treat stop as halt |
| strapDisable | input | 1 | Disable the watchdog |
| hvDetect | input | 1 | High voltage present on the programming pin |
| rstReq | output | 1 | One-cycle reset request |

## Verification
The counter is not visible at the ports, so a wrong count shows up only as a request that comes early, late or not at all. A counter that was cleared or held when it should not have been, or left alone when it should have been cleared, therefore appears as a pulse shifted by up to 8 ticks. The checks count the ticks from each stimulus to the next pulse and compare that number with the one the requirements give. A stray pulse during stop, while disabled or during a high-voltage detect is caught the cycle after it happens.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_HALT = 2'd2,
    MODE_STOP = 2'd3
  } cpu_mode_e;

  // strobes from control to counter datapath
  typedef struct packed {
    logic zero;     // force every stage to 0
    logic advance;  // count one tick
  } cop_strobe_t;

endpackage

// File: rtl/cop_wr_decode.sv
module cop_wr_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'h03F0
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              clrBit,
  output logic              clrHit
);

  logic addrMatch;

  always_comb begin
    addrMatch = (wrAddr == CLEAR_ADDR);
    // only a zero in the clear bit restarts the watchdog
    clrHit    = wrEn && addrMatch && !clrBit;
  end

endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
  import cop_pkg::*;
(
  input  logic        tick,
  input  logic        clrHit,
  input  logic [1:0]  cpuMode,
  input  logic        strapStopAsHalt,
  input  logic        strapDisable,
  input  logic        hvDetect,
  output cop_strobe_t strobe
);

  cpu_mode_e mode;
  logic      stopped;
  logic      offLine;

  always_comb begin
    mode    = cpu_mode_e'(cpuMode);
    stopped = (mode == MODE_STOP) && !strapStopAsHalt;
    offLine = strapDisable || hvDetect;
  end

  // clear dominates any tick in the same cycle
  always_comb begin
    strobe.zero    = offLine || stopped || clrHit;
    strobe.advance = tick && !strobe.zero;
  end

endmodule

// File: rtl/cop_datapath.sv
module cop_datapath
  import cop_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  cop_strobe_t strobe,
  output logic        rstReq
);

  logic [STAGES-1:0] stageQ;
  logic [STAGES:0]   carry;

  assign carry[0] = strobe.advance;

  // one toggle stage per bit, rippling the carry upward
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] && stageQ[i];

    always_ff @(posedge clk) begin
      if (!rstN || strobe.zero) begin
        stageQ[i] <= 1'b0;
      end else if (carry[i]) begin
        stageQ[i] <= ~stageQ[i];
      end
    end
  end

  // carry out of the last stage marks the wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstReq <= 1'b0;
    end else begin
      rstReq <= carry[STAGES];
    end
  end

endmodule

// File: rtl/cop_guard.sv
module cop_guard
  import cop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int STAGES = 3,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        cpuMode,
  input  logic              strapStopAsHalt,
  input  logic              strapDisable,
  input  logic              hvDetect,
  output logic              rstReq
);

  cop_strobe_t strobe;
  logic        clrHit;
  logic        unusedDataBits;

  // upper data bits carry no meaning for this block
  assign unusedDataBits = &{1'b0, wrData[DATA_W-1:1]};

  cop_wr_decode #(
    .ADDR_W    (ADDR_W),
    .CLEAR_ADDR(CLEAR_ADDR)
  ) u_dec (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .clrBit(wrData[0]),
    .clrHit(clrHit)
  );

  cop_ctrl u_ctrl (
    .tick           (tick),
    .clrHit         (clrHit),
    .cpuMode        (cpuMode),
    .strapStopAsHalt(strapStopAsHalt),
    .strapDisable   (strapDisable),
    .hvDetect       (hvDetect),
    .strobe         (strobe)
  );

  cop_datapath #(
    .STAGES(STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rstReq(rstReq)
  );

endmodule

// File: rtl/cop_guard_chk.sv
module cop_guard_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'h03F0
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              clrBit,
  input logic [1:0]        cpuMode,
  input logic              strapStopAsHalt,
  input logic              strapDisable,
  input logic              hvDetect,
  input logic              rstReq
);

  logic clearWrite;
  assign clearWrite = wrEn && (wrAddr == CLEAR_ADDR) && !clrBit;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);  // R2

  AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !rstReq);  // R1

  AST_CLEAR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    clearWrite |=> !rstReq);  // R5

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMode == 2'd3 && !strapStopAsHalt) |=> !rstReq);  // R7

  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strapDisable |=> !rstReq);  // R9

  AST_HV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    hvDetect |=> !rstReq);  // R10

  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |=> !rstReq);  // R11

endmodule

bind cop_guard cop_guard_chk #(
  .ADDR_W    (ADDR_W),
  .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .tick           (tick),
  .wrEn           (wrEn),
  .wrAddr         (wrAddr),
  .clrBit         (wrData[0]),
  .cpuMode        (cpuMode),
  .strapStopAsHalt(strapStopAsHalt),
  .strapDisable   (strapDisable),
  .hvDetect       (hvDetect),
  .rstReq         (rstReq)
);

// File: tb/sim_cop_guard.sv
module sim_cop_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  cpuMode = 2'd0;
  logic        strapStopAsHalt = 1'b0;
  logic        strapDisable = 1'b0;
  logic        hvDetect = 1'b0;
  logic        rstReq;

  int vectors = 0;
  int misses = 0;

  always #2 clk = ~clk;  // 250 MHz

  cop_guard u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cpuMode(cpuMode), .strapStopAsHalt(strapStopAsHalt),
    .strapDisable(strapDisable), .hvDetect(hvDetect), .rstReq(rstReq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic applyTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticksNoPulse(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      applyTick();
      if (rstReq) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic countToPulse(input int expN, input string tag);
    int at = 0;
    for (int k = 1; k <= 12; k++) begin
      applyTick();
      if (rstReq) begin
        at = k;
        break;
      end
    end
    check(at == expN, tag, at, expN);
    @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(rstReq == 1'b0, "R11 low in reset", rstReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rstReq == 1'b0, "R11 low after release", rstReq, 0);
    countToPulse(8, "R11 count starts at zero");
  endtask

  task automatic tRunAndPulse();
    int width = 0;
    for (int k = 1; k <= 8; k++) begin
      applyTick();
      check(rstReq == (k == 8), "R1 pulse on eighth tick", rstReq, int'(k == 8));
    end
    for (int k = 0; k < 4; k++) begin
      if (rstReq) width++;
      @(negedge clk);
    end
    check(width == 1, "R2 one-cycle pulse", width, 1);
    countToPulse(8, "R2 restart from zero");
  endtask

  task automatic tClear();
    ticksNoPulse(5, "R3 pre-clear");
    cpuWrite(16'h03F0, 8'h00);
    countToPulse(8, "R3 clear with 00");
    ticksNoPulse(6, "R3 pre-clear FE");
    cpuWrite(16'h03F0, 8'hFE);
    countToPulse(8, "R3 clear with FE ignores upper bits");
  endtask

  task automatic tIgnored();
    ticksNoPulse(5, "R4 pre-write");
    cpuWrite(16'h03F0, 8'h01);
    cpuWrite(16'h03F1, 8'h00);
    cpuWrite(16'h13F0, 8'h00);
    countToPulse(3, "R4 non-clearing writes keep count");
  endtask

  task automatic tClearVsTick();
    ticksNoPulse(6, "R5 pre");
    tick = 1'b1; wrEn = 1'b1; wrAddr = 16'h03F0; wrData = 8'h00;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0; wrAddr = '0;
    check(rstReq == 1'b0, "R5 no pulse", rstReq, 0);
    countToPulse(8, "R5 clear wins over tick");
  endtask

  task automatic tModes();
    cpuMode = 2'd1;
    ticksNoPulse(3, "R6 wait");
    cpuMode = 2'd2;
    ticksNoPulse(2, "R6 halt");
    countToPulse(3, "R6 count kept across wait and halt");
    cpuMode = 2'd0;
  endtask

  task automatic tStop();
    ticksNoPulse(5, "R7 pre-stop");
    cpuMode = 2'd3;
    ticksNoPulse(20, "R7 no pulse in stop");
    cpuMode = 2'd0;
    countToPulse(8, "R7 stop zeroed counter");
  endtask

  task automatic tStopAsHalt();
    strapStopAsHalt = 1'b1;
    ticksNoPulse(5, "R8 pre");
    cpuMode = 2'd3;
    countToPulse(3, "R8 stop acts as halt");
    cpuMode = 2'd0;
    strapStopAsHalt = 1'b0;
  endtask

  task automatic tDisable();
    ticksNoPulse(4, "R9 pre");
    strapDisable = 1'b1;
    ticksNoPulse(20, "R9 disabled never fires");
    strapDisable = 1'b0;
    countToPulse(8, "R9 held at zero");
  endtask

  task automatic tHighVolt();
    ticksNoPulse(5, "R10 pre");
    hvDetect = 1'b1;
    ticksNoPulse(12, "R10 quiet under detect");
    hvDetect = 1'b0;
    countToPulse(8, "R10 restarts from zero");
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tRunAndPulse();
    tClear();
    tIgnored();
    tClearVsTick();
    tModes();
    tStop();
    tStopAsHalt();
    tDisable();
    tHighVolt();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    misses++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule